// File: doc/BRIEF.md
# APB UART Register Front End

This block is the register side of a UART, attached to an APB bus. A small word-addressed window holds five slots: data, status, control, scaler and a FIFO-debug slot. Software reads the data slot to take the oldest byte from a 16-entry receive FIFO. It writes the data slot to hand one byte to the transmit path. The control word is stored whole and gates both directions. The status word reports receive occupancy and transmit holding state. A single interrupt line pulses once for each qualifying event.

Received bytes enter through a valid/ready side port. A byte transfers on a clock edge where `rx_valid` and `rx_ready` are both high. While receive is enabled, `rx_ready` falls when the FIFO is full, and the source must hold the byte until `rx_ready` returns. While receive is disabled, `rx_ready` stays high and bytes are taken and discarded.

Transmit bytes leave through a one-entry holding register. `tx_valid` stays high, with `tx_data` stable, until the sink raises `tx_ready`. Serial bit timing, baud scaling and parity are handled elsewhere.

Top module: `apb_uart_front`

## Requirements
- R1: After reset, control reads 0x0 and status reads 0x6 (bits 1 and 2 set). The receive FIFO is empty, `tx_valid` and `irq` are low.
- R2: The control slot (offset 0x08) stores all 32 bits of a write and reads them back unchanged. Control bits: 0 receive enable, 1 transmit enable, 2 receive interrupt enable, 3 transmit interrupt enable.
- R3: The status slot (offset 0x04) ignores writes.
- R4: While control bit 0 is clear, an incoming byte is accepted and discarded. It does not change status or the data read.
- R5: While control bit 0 is set, each accepted byte is stored and sets status bit 0 (data ready).
- R6: A read of the data slot returns the oldest stored byte in bits 7:0 and removes it. Status bit 0 clears when the FIFO becomes empty. A read of an empty FIFO returns 0.
- R7: The receive FIFO holds 16 bytes. Status bit 8 is set while it holds at least 8, and status bit 10 is set while it holds 16. With receive enabled, `rx_ready` is low exactly while the FIFO is full.
- R8: A write to the data slot with control bit 1 set loads `pwdata[7:0]` into the transmit holding register and raises `tx_valid`. With bit 1 clear, the write does nothing. A write while `tx_valid` is already high is dropped. While holding a byte, status bits 1 and 2 are clear and bit 9 is set.
- R9: `irq` goes high for one cycle, in the cycle after a stored receive byte (when control bit 2 is set) or a loaded transmit byte (when control bit 3 is set). A receive event and a transmit event in the same cycle give a single pulse.
- R10: Decoding uses `paddr[7:0]`. Offset 0x03 behaves as the data slot for reads and writes. The scaler (0x0C), FIFO-debug (0x10) and all undecoded offsets read 0 and ignore writes.
- R11: Every APB transfer completes with zero wait states (`pready` high) and `pslverr` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Clock |
| presetn | input | 1 | Active-low synchronous reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB write when high |
| paddr | input | ADDR_W (8) | APB byte address |
| pwdata | input | 32 | APB write data |
| prdata | output | 32 | APB read data |
| pready | output | 1 | Transfer complete (always high) |
| pslverr | output | 1 | Transfer error (always low) |
| rx_valid | input | 1 | Incoming byte present |
| rx_data | input | 8 | Incoming byte |
| rx_ready | output | 1 | Block can take an incoming byte |
| tx_valid | output | 1 | Transmit byte present |
| tx_data | output | 8 | Transmit byte |
| tx_ready | input | 1 | Sink takes the transmit byte |
| irq | output | 1 | Interrupt pulse |

## Verification
The bench fills the receive FIFO one byte at a time and checks the half and full flags and `rx_ready` after every byte. A wrong threshold or an off-by-one count shows up as a flag at the wrong occupancy, or as a 17th byte that is silently taken. It then drains the FIFO and compares the byte order. A read of the now-empty FIFO must return 0 and not a stale entry. Further checks cover:
- disabled receive, which must leave no trace in status;
- a second transmit write while a byte is held, which must not overwrite the held byte;
- a receive and a transmit event in the same cycle, where a design that summed the events would stretch or double the pulse;
- the offset-3 alias and the scaler slot, where a loose decoder would write or read the wrong register.

// File: rtl/apbu_pkg.sv
package apbu_pkg;
  localparam int unsigned DW = 32;

  localparam logic [7:0] OFS_DATA   = 8'h00;
  localparam logic [7:0] OFS_DATA_B = 8'h03;
  localparam logic [7:0] OFS_STAT   = 8'h04;
  localparam logic [7:0] OFS_CTRL   = 8'h08;
  localparam logic [7:0] OFS_SCALE  = 8'h0C;
  localparam logic [7:0] OFS_DEBUG  = 8'h10;

  localparam int unsigned C_RXEN = 0;
  localparam int unsigned C_TXEN = 1;
  localparam int unsigned C_RXIE = 2;
  localparam int unsigned C_TXIE = 3;

  localparam int unsigned S_DREADY  = 0;
  localparam int unsigned S_TSHEMP  = 1;
  localparam int unsigned S_TFEMP   = 2;
  localparam int unsigned S_RHALF   = 8;
  localparam int unsigned S_TFULL   = 9;
  localparam int unsigned S_RFULL   = 10;

  typedef enum logic [2:0] {
    SLOT_DATA, SLOT_STAT, SLOT_CTRL, SLOT_SCALE, SLOT_DEBUG, SLOT_NONE
  } slot_e;
endpackage

// File: rtl/apbu_decode.sv
module apbu_decode
  import apbu_pkg::*;
#(
  parameter int unsigned ADDR_W = 8
) (
  input  logic [ADDR_W-1:0] addr,
  output slot_e             slot
);
  localparam int unsigned DEC_W = 8;
  logic [DEC_W-1:0] low;

  assign low = addr[DEC_W-1:0];

  always_comb begin
    unique case (low)
      OFS_DATA, OFS_DATA_B: slot = SLOT_DATA;
      OFS_STAT:             slot = SLOT_STAT;
      OFS_CTRL:             slot = SLOT_CTRL;
      OFS_SCALE:            slot = SLOT_SCALE;
      OFS_DEBUG:            slot = SLOT_DEBUG;
      default:              slot = SLOT_NONE;
    endcase
  end
endmodule

// File: rtl/apbu_rx_fifo.sv
module apbu_rx_fifo #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned BW    = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [BW-1:0] wdata,
  input  logic          pop,
  output logic [BW-1:0] head,
  output logic          empty,
  output logic          full,
  output logic          half
);
  localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = PW + 1;
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);
  localparam logic [CW-1:0] HALF_CNT = CW'(DEPTH / 2);
  localparam logic [PW-1:0] LAST     = PW'(DEPTH - 1);

  logic [BW-1:0] mem [DEPTH];
  logic [PW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] count;

  assign empty = (count == '0);
  assign full  = (count == FULL_CNT);
  assign half  = (count >= HALF_CNT);
  assign head  = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
      if (pop)  rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  // R7: a push never lands on a full FIFO unless a pop frees a slot
  assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> (!full || pop));

  // R6: a pop is only issued against a non-empty FIFO
  assert_no_underflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty);
endmodule

// File: rtl/apbu_tx_hold.sv
module apbu_tx_hold #(
  parameter int unsigned BW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_req,
  input  logic [BW-1:0] load_data,
  output logic          loaded,
  output logic          out_valid,
  output logic [BW-1:0] out_data,
  input  logic          out_ready
);
  assign loaded = load_req && !out_valid;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (loaded) begin
      out_valid <= 1'b1;
      out_data  <= load_data;
    end else if (out_valid && out_ready) begin
      out_valid <= 1'b0;
    end
  end

  // R8: a held byte stays put until the sink takes it
  assert_tx_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));
endmodule

// File: rtl/apb_uart_front.sv
module apb_uart_front
  import apbu_pkg::*;
#(
  parameter int unsigned ADDR_W   = 8,
  parameter int unsigned RX_DEPTH = 16
) (
  input  logic              pclk,
  input  logic              presetn,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [DW-1:0]     pwdata,
  output logic [DW-1:0]     prdata,
  output logic              pready,
  output logic              pslverr,
  input  logic              rx_valid,
  input  logic [7:0]        rx_data,
  output logic              rx_ready,
  output logic              tx_valid,
  output logic [7:0]        tx_data,
  input  logic              tx_ready,
  output logic              irq
);
  localparam int unsigned BW = 8;

  slot_e         slot;
  logic          access, wr_acc, rd_acc;
  logic [DW-1:0] ctrl_q;
  logic [DW-1:0] status;
  logic          rx_store, rx_pop;
  logic [BW-1:0] rx_head;
  logic          rx_empty, rx_full, rx_half;
  logic          tx_req, tx_loaded;
  logic          irq_q;

  apbu_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr (paddr),
    .slot (slot)
  );

  assign access = psel && penable;
  assign wr_acc = access && pwrite;
  assign rd_acc = access && !pwrite;
  assign pready  = 1'b1;
  assign pslverr = 1'b0;

  always_ff @(posedge pclk) begin
    if (!presetn)                          ctrl_q <= '0;
    else if (wr_acc && slot == SLOT_CTRL)  ctrl_q <= pwdata;
  end

  assign rx_ready = !ctrl_q[C_RXEN] || !rx_full;
  assign rx_store = rx_valid && rx_ready && ctrl_q[C_RXEN];
  assign rx_pop   = rd_acc && (slot == SLOT_DATA) && !rx_empty;

  apbu_rx_fifo #(.DEPTH(RX_DEPTH), .BW(BW)) u_rxq (
    .clk   (pclk),
    .rst_n (presetn),
    .push  (rx_store),
    .wdata (rx_data),
    .pop   (rx_pop),
    .head  (rx_head),
    .empty (rx_empty),
    .full  (rx_full),
    .half  (rx_half)
  );

  assign tx_req = wr_acc && (slot == SLOT_DATA) && ctrl_q[C_TXEN];

  apbu_tx_hold #(.BW(BW)) u_txh (
    .clk       (pclk),
    .rst_n     (presetn),
    .load_req  (tx_req),
    .load_data (pwdata[BW-1:0]),
    .loaded    (tx_loaded),
    .out_valid (tx_valid),
    .out_data  (tx_data),
    .out_ready (tx_ready)
  );

  always_comb begin
    status           = '0;
    status[S_DREADY] = !rx_empty;
    status[S_TSHEMP] = !tx_valid;
    status[S_TFEMP]  = !tx_valid;
    status[S_RHALF]  = rx_half;
    status[S_TFULL]  = tx_valid;
    status[S_RFULL]  = rx_full;
  end

  always_comb begin
    unique case (slot)
      SLOT_DATA: prdata = rx_empty ? '0 : DW'(rx_head);
      SLOT_STAT: prdata = status;
      SLOT_CTRL: prdata = ctrl_q;
      default:   prdata = '0;
    endcase
  end

  always_ff @(posedge pclk) begin
    if (!presetn) irq_q <= 1'b0;
    else irq_q <= (rx_store && ctrl_q[C_RXIE]) || (tx_loaded && ctrl_q[C_TXIE]);
  end
  assign irq = irq_q;

  // R9: every pulse follows a stored or loaded byte one cycle earlier
  assert_irq_cause_R9: assert property (@(posedge pclk) disable iff (!presetn)
    $rose(irq) |-> ($past(rx_store) || $past(tx_loaded)));

  // R7: with receive on, back-pressure exactly while full
  assert_rx_backpressure_R7: assert property (@(posedge pclk) disable iff (!presetn)
    ctrl_q[C_RXEN] |-> (rx_ready == !rx_full));

  // R4: with receive off, nothing enters the FIFO
  assert_rx_gate_R4: assert property (@(posedge pclk) disable iff (!presetn)
    (!ctrl_q[C_RXEN] && rx_empty && !rx_pop) |=> rx_empty);
endmodule

// File: tb/apb_uart_front_bench.sv
`timescale 1ns/1ps
module apb_uart_front_bench;
  localparam int unsigned AW = 8;
  localparam int unsigned DEPTH = 16;

  logic        pclk = 1'b0;
  logic        presetn;
  logic        psel, penable, pwrite;
  logic [AW-1:0] paddr;
  logic [31:0] pwdata, prdata;
  logic        pready, pslverr;
  logic        rx_valid, rx_ready;
  logic [7:0]  rx_data;
  logic        tx_valid, tx_ready;
  logic [7:0]  tx_data;
  logic        irq;

  int total = 0;
  int bad   = 0;
  logic irq_seen;

  always #10 pclk = ~pclk;

  apb_uart_front u_apb_uart_front (
    .pclk(pclk), .presetn(presetn), .psel(psel), .penable(penable),
    .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
    .pready(pready), .pslverr(pslverr), .rx_valid(rx_valid),
    .rx_data(rx_data), .rx_ready(rx_ready), .tx_valid(tx_valid),
    .tx_data(tx_data), .tx_ready(tx_ready), .irq(irq)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic apb_wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge pclk);
    psel = 1; penable = 0; pwrite = 1; paddr = a; pwdata = d;
    @(negedge pclk);
    penable = 1;
    chk(pready === 1'b1 && pslverr === 1'b0, "R11 write", {pready, pslverr}, 2'b10);
    @(negedge pclk);
    psel = 0; penable = 0; pwrite = 0;
    irq_seen = irq;
  endtask

  task automatic apb_rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge pclk);
    psel = 1; penable = 0; pwrite = 0; paddr = a;
    @(negedge pclk);
    penable = 1;
    d = prdata;
    chk(pready === 1'b1 && pslverr === 1'b0, "R11 read", {pready, pslverr}, 2'b10);
    @(negedge pclk);
    psel = 0; penable = 0;
  endtask

  task automatic rx_send(input logic [7:0] b, output bit taken);
    @(negedge pclk);
    rx_valid = 1; rx_data = b;
    taken = rx_ready;
    @(negedge pclk);
    rx_valid = 0;
    irq_seen = irq;
  endtask

  initial begin
    #(20ns * 150000);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] r;
    bit tk;
    presetn = 0; psel = 0; penable = 0; pwrite = 0; paddr = '0; pwdata = '0;
    rx_valid = 0; rx_data = '0; tx_ready = 0;
    repeat (3) @(negedge pclk);
    presetn = 1;

    // R1 reset state
    chk(irq === 1'b0 && tx_valid === 1'b0, "R1 irq/tx_valid", {irq, tx_valid}, 0);
    apb_rd(8'h04, r); chk(r === 32'h6, "R1 status", r, 32'h6);
    apb_rd(8'h08, r); chk(r === 32'h0, "R1 control", r, 0);
    apb_rd(8'h00, r); chk(r === 32'h0, "R1 data empty", r, 0);

    // R2 control readback, R3 status ignores writes
    apb_wr(8'h08, 32'hFFFF_FFF0); apb_rd(8'h08, r);
    chk(r === 32'hFFFF_FFF0, "R2 control", r, 32'hFFFF_FFF0);
    apb_wr(8'h08, 32'h8000_1230); apb_rd(8'h08, r);
    chk(r === 32'h8000_1230, "R2 control", r, 32'h8000_1230);
    apb_wr(8'h04, 32'hFFFF_FFFF); apb_rd(8'h04, r);
    chk(r === 32'h6, "R3 status write", r, 32'h6);

    // R10 scaler/debug/undecoded read 0, writes ignored
    apb_wr(8'h0C, 32'h1234); apb_rd(8'h0C, r); chk(r === 0, "R10 scaler", r, 0);
    apb_wr(8'h10, 32'h55);   apb_rd(8'h10, r); chk(r === 0, "R10 debug", r, 0);
    apb_rd(8'h14, r); chk(r === 0, "R10 undecoded", r, 0);
    apb_rd(8'h08, r); chk(r === 32'h8000_1230, "R10 ctrl untouched", r, 32'h8000_1230);

    // R4 receive disabled: byte taken and discarded
    apb_wr(8'h08, 32'h4);
    rx_send(8'hA5, tk);
    chk(tk && !irq_seen, "R4 taken no irq", {tk, irq_seen}, 2'b10);
    apb_rd(8'h04, r); chk(r === 32'h6, "R4 status", r, 32'h6);
    apb_rd(8'h00, r); chk(r === 0, "R4 data", r, 0);

    // R5/R6/R9 receive with interrupt
    apb_wr(8'h08, 32'h5);
    rx_send(8'h3C, tk);
    chk(tk && irq_seen, "R9 rx irq", {tk, irq_seen}, 2'b11);
    @(negedge pclk); chk(irq === 1'b0, "R9 one cycle", irq, 0);
    apb_rd(8'h04, r); chk(r[0] === 1'b1, "R5 data ready", r, 32'h7);
    apb_rd(8'h03, r); chk(r === 32'h3C, "R6/R10 pop at +3", r, 32'h3C);
    apb_rd(8'h04, r); chk(r[0] === 1'b0, "R6 ready clears", r, 32'h6);

    // R7 fill sweep, no interrupt
    apb_wr(8'h08, 32'h1);
    for (int i = 0; i < DEPTH; i++) begin
      rx_send(8'((i * 37 + 11) & 8'hFF), tk);
      chk(tk && !irq_seen, "R7 push", {tk, irq_seen}, 2'b10);
      apb_rd(8'h04, r);
      chk(r[8] === (i + 1 >= DEPTH / 2) && r[10] === (i + 1 == DEPTH) && r[0] === 1'b1,
          "R7 flags", r, {21'b0, (i + 1 == DEPTH), 1'b0, (i + 1 >= DEPTH / 2), 8'h07});
      chk(rx_ready === (i + 1 < DEPTH), "R7 rx_ready", rx_ready, (i + 1 < DEPTH));
    end
    rx_send(8'hEE, tk); chk(!tk, "R7 full refuses", tk, 0);
    for (int i = 0; i < DEPTH; i++) begin
      apb_rd(8'h00, r);
      chk(r === ((i * 37 + 11) & 32'hFF), "R6 order", r, (i * 37 + 11) & 32'hFF);
    end
    apb_rd(8'h00, r); chk(r === 0, "R6 empty read", r, 0);
    apb_rd(8'h04, r); chk(r === 32'h6, "R6 status empty", r, 32'h6);

    // R8 transmit gated
    apb_wr(8'h08, 32'h8);
    apb_wr(8'h00, 32'h0000_0177);
    chk(tx_valid === 1'b0 && !irq_seen, "R8 tx disabled", {tx_valid, irq_seen}, 0);
    apb_wr(8'h08, 32'hA);
    apb_wr(8'h00, 32'hABCD_0177);
    chk(tx_valid === 1'b1 && tx_data === 8'h77 && irq_seen, "R8/R9 tx load",
        {tx_valid, irq_seen, tx_data}, {2'b11, 8'h77});
    apb_rd(8'h04, r); chk(r === 32'h200, "R8 status held", r, 32'h200);
    apb_wr(8'h03, 32'h99);
    chk(tx_data === 8'h77 && !irq_seen, "R8 busy drop", {irq_seen, tx_data}, 8'h77);
    @(negedge pclk); tx_ready = 1;
    @(negedge pclk); tx_ready = 0;
    chk(tx_valid === 1'b0, "R8 handshake", tx_valid, 0);
    apb_wr(8'h03, 32'h42);
    chk(tx_valid === 1'b1 && tx_data === 8'h42, "R10 tx at +3", tx_data, 8'h42);
    @(negedge pclk); tx_ready = 1;
    @(negedge pclk); tx_ready = 0;

    // R9 simultaneous rx and tx events -> one single-cycle pulse
    apb_wr(8'h08, 32'hF);
    @(negedge pclk);
    psel = 1; pwrite = 1; paddr = 8'h00; pwdata = 32'h11;
    @(negedge pclk);
    penable = 1; rx_valid = 1; rx_data = 8'h22;
    @(negedge pclk);
    psel = 0; penable = 0; pwrite = 0; rx_valid = 0;
    chk(irq === 1'b1 && tx_valid === 1'b1, "R9 merged pulse", {irq, tx_valid}, 2'b11);
    @(negedge pclk); chk(irq === 1'b0, "R9 merged one cycle", irq, 0);
    apb_rd(8'h00, r); chk(r === 32'h22, "R5 merged rx byte", r, 32'h22);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule